// File: doc/BRIEF.md
# Speculative Cache Violation Tracker

This block sits beside a small direct-mapped cache in a node that runs all of its work as speculative transactions. For every line it keeps a tag, a valid flag, one data word, and two speculative flags. The read flag records that the running transaction loaded from the line. The modified flag records that the transaction stored to it. Each line therefore holds its data either in committed form or in speculatively modified form.

Other nodes broadcast the addresses of their committed writes, and the block snoops each one. A snooped address that hits a line the local transaction has read is a dependence violation. The block then raises a sticky violation flag, drops every speculatively modified line, and clears all speculative flags so that the transaction can start again. A snoop that violates nothing still acts on the line it names. Without data it invalidates the line. With data it updates the line, unless the line holds local speculative data. When the local transaction commits, a single pulse clears every speculative flag.

Top module: `spec_viol_tracker`

## Requirements
- R1: After reset no line is valid, `violation` is 0 and `ld_hit` is 0, so a load to any address misses.
- R2: An address splits into a line index in its low log2(NUM_LINES) bits and a tag in the remaining upper bits. `cpu_op` encodes 0 fill, 1 load, 2 store and 3 idle. A fill writes the tag and data and leaves the line valid with both speculative flags clear. On the edge that takes a load, `ld_hit` and `ld_data` are registered: `ld_hit` is 1 only when the indexed line is valid with an equal tag, and `ld_data` then holds that line's data.
- R3: A load that hits sets the line's read flag, so a later snoop of that address raises `violation`.
- R4: A store that hits replaces the line's data with `cpu_wdata` and sets its modified flag. A store that misses changes nothing.
- R5: A snoop whose address hits a line with its read flag set sets `violation` on the next edge. The flag stays 1 until `restart_ack` is sampled, and it is 0 on the edge after that.
- R6: In the cycle a violation is raised, every line with its modified flag set becomes invalid, and all read and modified flags are cleared.
- R7: A snoop that hits a line without local speculative data invalidates the line when `snp_has_data` is 0. When `snp_has_data` is 1, it replaces the line's data with `snp_data` and the line stays valid.
- R8: A snoop that hits a line whose modified flag is set but whose read flag is clear raises no violation, and the line keeps its speculative data.
- R9: A snoop whose address hits no valid line raises no violation and changes no line.
- R10: A `commit_done` pulse clears all read and modified flags in one cycle and leaves lines valid with their data. After the pulse, a snoop of a previously read line raises no violation, and a snoop with data updates a previously modified line.
- R11: While `violation` is 1, no snoop raises a further violation. Processor loads, stores and fills are ignored: a load returns `ld_hit` 0.
- R12: In one cycle a snoop takes precedence over `commit_done`, and `commit_done` takes precedence over a processor access. The losing request is dropped.
- R13: A fill to a line that is valid with its modified flag set is refused, and the line keeps its tag and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_op | input | 2 | Processor request: 0 fill, 1 load, 2 store, 3 idle |
| cpu_addr | input | ADDR_W | Processor address, tag above the line index |
| cpu_wdata | input | DATA_W | Data for a fill or a store |
| ld_hit | output | 1 | Registered: the last taken load hit |
| ld_data | output | DATA_W | Registered data of the last load that hit |
| snp_valid | input | 1 | A snooped commit address is present |
| snp_addr | input | ADDR_W | Snooped commit address |
| snp_has_data | input | 1 | The snoop carries data (update) rather than address only (invalidate) |
| snp_data | input | DATA_W | Snooped data word |
| commit_done | input | 1 | Pulse: the local transaction has committed |
| restart_ack | input | 1 | The processor has restarted after a violation |
| violation | output | 1 | Sticky dependence-violation flag |

## Verification
The hardest case to reach from the ports is the violation cycle itself. In that cycle the tracker must invalidate modified lines, clear every flag and act on the snooped line all at once, and it must then hold the violation while the system around it keeps sending snoops and processor requests. The bench first builds a state with read, modified and clean lines through a chosen order of fills, loads and stores. It fires a single violating snoop and keeps `restart_ack` low for several cycles. During that window it sends further snoops and ignored accesses, and each line is examined with loads after the acknowledge. Three-way collisions of snoop, commit and store in one cycle are driven directly, and a sweep of fills and loads over every index and tag checks the tag match.

// File: rtl/sct_pkg.sv
package sct_pkg;

  typedef enum logic [1:0] {
    CPU_FILL  = 2'd0,
    CPU_LOAD  = 2'd1,
    CPU_STORE = 2'd2,
    CPU_IDLE  = 2'd3
  } cpu_op_e;

  // per-line update command, built by the top each cycle
  typedef struct packed {
    logic install;   // write tag and data, mark valid and clean
    logic write;     // replace data word
    logic set_rd;    // mark speculatively read
    logic set_mod;   // mark speculatively modified
    logic inval;     // drop the line
    logic clr;       // clear speculative flags
  } line_cmd_t;

endpackage

// File: rtl/sct_lookup.sv
module sct_lookup #(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 4,
  parameter int IDX_W     = 2
) (
  input  logic [IDX_W-1:0]                idx,
  input  logic [TAG_W-1:0]                tag,
  input  logic [NUM_LINES-1:0]            valid_vec,
  input  logic [NUM_LINES-1:0][TAG_W-1:0] tag_vec,
  output logic [NUM_LINES-1:0]            match
);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_cmp
    assign match[i] = valid_vec[i] && (tag_vec[i] == tag) && (idx == IDX_W'(i));
  end

endmodule

// File: rtl/sct_line.sv
module sct_line
  import sct_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_cmd_t         cmd,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              valid_o,
  output logic              rd_o,
  output logic              mod_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] data_o
);

  logic              valid_q, valid_n;
  logic              rd_q, rd_n;
  logic              mod_q, mod_n;
  logic [TAG_W-1:0]  tag_q, tag_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              upd_en;

  assign upd_en = |cmd;

  always_comb begin
    valid_n = valid_q;
    rd_n    = rd_q;
    mod_n   = mod_q;
    tag_n   = tag_q;
    data_n  = data_q;
    if (cmd.clr) begin
      rd_n  = 1'b0;
      mod_n = 1'b0;
    end
    if (cmd.inval) begin
      valid_n = 1'b0;
      rd_n    = 1'b0;
      mod_n   = 1'b0;
    end
    if (cmd.install) begin
      valid_n = 1'b1;
      tag_n   = tag_in;
      data_n  = data_in;
      rd_n    = 1'b0;
      mod_n   = 1'b0;
    end
    if (cmd.write)   data_n = data_in;
    if (cmd.set_rd)  rd_n   = 1'b1;
    if (cmd.set_mod) mod_n  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rd_q    <= 1'b0;
      mod_q   <= 1'b0;
      tag_q   <= '0;
      data_q  <= '0;
    end else if (upd_en) begin
      valid_q <= valid_n;
      rd_q    <= rd_n;
      mod_q   <= mod_n;
      tag_q   <= tag_n;
      data_q  <= data_n;
    end
  end

  assign valid_o = valid_q;
  assign rd_o    = rd_q;
  assign mod_o   = mod_q;
  assign tag_o   = tag_q;
  assign data_o  = data_q;

  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q || mod_q) |-> valid_q); // R6

  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.clr && !cmd.set_rd && !cmd.set_mod) |=> (!rd_q && !mod_q)); // R10

  AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.install |=> (valid_q && !rd_q && !mod_q)); // R2

endmodule

// File: rtl/sct_viol.sv
module sct_viol (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic ack,
  output logic viol
);

  logic viol_q, viol_n;

  always_comb begin
    viol_n = viol_q;
    if (raise)    viol_n = 1'b1;
    else if (ack) viol_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_n;
  end

  assign viol = viol_q;

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_q && !ack) |=> viol_q); // R5

  AST_VIOL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_q && ack) |=> !viol_q); // R5

  AST_NO_SECOND_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> !raise); // R11

endmodule

// File: rtl/spec_viol_tracker.sv
module spec_viol_tracker
  import sct_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_has_data,
  input  logic [DATA_W-1:0] snp_data,
  input  logic              commit_done,
  input  logic              restart_ack,
  output logic              violation
);

  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  cpu_op_e                          op;
  logic [IDX_W-1:0]                 cpu_idx, snp_idx;
  logic [TAG_W-1:0]                 cpu_tag, snp_tag;
  logic [NUM_LINES-1:0]             valid_vec, rd_vec, mod_vec;
  logic [NUM_LINES-1:0][TAG_W-1:0]  tag_vec;
  logic [NUM_LINES-1:0][DATA_W-1:0] data_vec;
  logic [NUM_LINES-1:0]             cpu_match, snp_match;
  logic                             snp_hit, snp_rd_hit, viol_raise;
  logic                             commit_take, cpu_take, load_take;
  logic [DATA_W-1:0]                line_din;
  logic                             ld_hit_n;
  logic [DATA_W-1:0]                ld_data_n;

  assign op      = cpu_op_e'(cpu_op);
  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  sct_lookup #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_cpu_lookup (
    .idx       (cpu_idx),
    .tag       (cpu_tag),
    .valid_vec (valid_vec),
    .tag_vec   (tag_vec),
    .match     (cpu_match)
  );

  sct_lookup #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_snp_lookup (
    .idx       (snp_idx),
    .tag       (snp_tag),
    .valid_vec (valid_vec),
    .tag_vec   (tag_vec),
    .match     (snp_match)
  );

  // arbitration: snoop over commit over processor access
  assign snp_hit     = |snp_match;
  assign snp_rd_hit  = |(snp_match & rd_vec);
  assign viol_raise  = snp_valid && snp_rd_hit && !violation;
  assign commit_take = commit_done && !snp_valid;
  assign cpu_take    = !snp_valid && !commit_done && !violation && (op != CPU_IDLE);
  assign load_take   = cpu_take && (op == CPU_LOAD);
  assign line_din    = snp_valid ? snp_data : cpu_wdata;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    line_cmd_t cmd;
    logic      sel_cpu;

    assign sel_cpu = (cpu_idx == IDX_W'(i));

    always_comb begin
      cmd = '0;
      if (viol_raise) begin
        cmd.clr   = 1'b1;
        cmd.inval = mod_vec[i] || (snp_match[i] && !snp_has_data);
        cmd.write = snp_match[i] && snp_has_data && !mod_vec[i];
      end else if (snp_valid) begin
        if (snp_match[i] && !mod_vec[i]) begin
          cmd.inval = !snp_has_data;
          cmd.write = snp_has_data;
        end
      end else if (commit_take) begin
        cmd.clr = 1'b1;
      end else if (cpu_take && sel_cpu) begin
        unique case (op)
          CPU_FILL:  cmd.install = !(valid_vec[i] && mod_vec[i]);
          CPU_LOAD:  cmd.set_rd  = cpu_match[i];
          CPU_STORE: begin
            cmd.write   = cpu_match[i];
            cmd.set_mod = cpu_match[i];
          end
          default:   cmd = '0;
        endcase
      end
    end

    sct_line #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .tag_in  (cpu_tag),
      .data_in (line_din),
      .valid_o (valid_vec[i]),
      .rd_o    (rd_vec[i]),
      .mod_o   (mod_vec[i]),
      .tag_o   (tag_vec[i]),
      .data_o  (data_vec[i])
    );
  end

  sct_viol u_viol (
    .clk   (clk),
    .rst_n (rst_n),
    .raise (viol_raise),
    .ack   (restart_ack),
    .viol  (violation)
  );

  // load response
  always_comb begin
    ld_hit_n  = load_take && (|cpu_match);
    ld_data_n = data_vec[cpu_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_hit  <= 1'b0;
      ld_data <= '0;
    end else begin
      ld_hit <= ld_hit_n;
      if (ld_hit_n) ld_data <= ld_data_n;
    end
  end

  AST_RAISE_FROM_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(violation) |-> $past(snp_valid)); // R5

  AST_SNOOP_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_hit) |=> !$rose(violation)); // R9

  AST_LOAD_IGNORED_IN_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    (violation && cpu_op == 2'd1) |=> !ld_hit); // R11

  AST_COMMIT_BEATS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_done && cpu_op == 2'd1) |=> !ld_hit); // R12

endmodule

// File: tb/tb_spec_viol_tracker.sv
module tb_spec_viol_tracker;

  localparam int NL     = 4;
  localparam int AW     = 6;
  localparam int DW     = 8;
  localparam int NTAG   = 1 << (AW - 2);

  logic          clk;
  logic          rst_n;
  logic [1:0]    cpu_op;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          ld_hit;
  logic [DW-1:0] ld_data;
  logic          snp_valid;
  logic [AW-1:0] snp_addr;
  logic          snp_has_data;
  logic [DW-1:0] snp_data;
  logic          commit_done;
  logic          restart_ack;
  logic          violation;

  int n_checks = 0;
  int n_fail   = 0;

  spec_viol_tracker #(.NUM_LINES(NL), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_op       (cpu_op),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .ld_hit       (ld_hit),
    .ld_data      (ld_data),
    .snp_valid    (snp_valid),
    .snp_addr     (snp_addr),
    .snp_has_data (snp_has_data),
    .snp_data     (snp_data),
    .commit_done  (commit_done),
    .restart_ack  (restart_ack),
    .violation    (violation)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cpu_op = op; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_op = 2'd3;
  endtask

  task automatic snoop(input logic [AW-1:0] a, input logic hd, input logic [DW-1:0] d);
    snp_valid = 1'b1; snp_addr = a; snp_has_data = hd; snp_data = d;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic commit();
    commit_done = 1'b1;
    @(negedge clk);
    commit_done = 1'b0;
  endtask

  task automatic ack();
    restart_ack = 1'b1;
    @(negedge clk);
    restart_ack = 1'b0;
  endtask

  task automatic check_load(input string req, input logic [AW-1:0] a,
                            input logic eh, input logic [DW-1:0] ed);
    cpu(2'd1, a, '0);
    check(req, int'(ld_hit), int'(eh));
    if (eh) check(req, int'(ld_data), int'(ed));
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_op = 2'd3; cpu_addr = '0; cpu_wdata = '0;
    snp_valid = 1'b0; snp_addr = '0; snp_has_data = 1'b0; snp_data = '0;
    commit_done = 1'b0; restart_ack = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 violation", int'(violation), 0);
    check("R1 ld_hit", int'(ld_hit), 0);
    check_load("R1 load miss", 6'h00, 1'b0, '0);

    // R2 sweep: every index, every tag filled, every tag probed
    for (int i = 0; i < NL; i++) begin
      for (int t = 0; t < NTAG; t++) begin
        cpu(2'd0, AW'(t * NL + i), DW'(t * 16 + i * 3 + 5));
        for (int p = 0; p < NTAG; p++)
          check_load("R2 sweep", AW'(p * NL + i), (p == t), DW'(t * 16 + i * 3 + 5));
      end
    end
    commit();
    check("R10 commit after sweep", int'(violation), 0);

    // build read, modified and clean lines
    cpu(2'd0, 6'h04, 8'h11);
    cpu(2'd0, 6'h05, 8'h22);
    cpu(2'd0, 6'h06, 8'h33);
    cpu(2'd0, 6'h07, 8'h66);
    check_load("R2 load", 6'h04, 1'b1, 8'h11);
    check_load("R3 load read", 6'h06, 1'b1, 8'h33);
    cpu(2'd2, 6'h05, 8'h99);
    check_load("R4 store data", 6'h05, 1'b1, 8'h99);
    check("R3 no violation yet", int'(violation), 0);

    snoop(6'h04, 1'b0, '0);
    check("R3 R5 violation raised", int'(violation), 1);
    idle(3);
    check("R5 violation held", int'(violation), 1);
    check_load("R11 load ignored", 6'h07, 1'b0, '0);
    snoop(6'h07, 1'b1, 8'h5A);
    cpu(2'd2, 6'h07, 8'h77);
    ack();
    check("R5 ack clears", int'(violation), 0);
    idle(2);
    check("R11 no second violation", int'(violation), 0);
    snoop(6'h06, 1'b1, 8'h44);
    check("R6 read flags cleared", int'(violation), 0);
    check_load("R6 modified line dropped", 6'h05, 1'b0, '0);
    check_load("R7 invalidate", 6'h04, 1'b0, '0);
    check_load("R7 update", 6'h06, 1'b1, 8'h44);
    check_load("R11 store ignored", 6'h07, 1'b1, 8'h5A);
    commit();

    // R8 snoop to a modified, unread line
    cpu(2'd0, 6'h08, 8'h10);
    cpu(2'd2, 6'h08, 8'hAB);
    snoop(6'h08, 1'b1, 8'hCD);
    check("R8 no violation update", int'(violation), 0);
    snoop(6'h08, 1'b0, '0);
    check("R8 no violation inval", int'(violation), 0);
    check_load("R8 speculative data kept", 6'h08, 1'b1, 8'hAB);
    commit();

    // R10 after commit the modified flag is gone
    snoop(6'h08, 1'b1, 8'hCD);
    check("R10 no violation after commit", int'(violation), 0);
    check_load("R10 update after commit", 6'h08, 1'b1, 8'hCD);
    commit();

    // R9 snoop misses
    check_load("R9 load read", 6'h08, 1'b1, 8'hCD);
    snoop(6'h0C, 1'b1, 8'hEE);
    check("R9 tag mismatch", int'(violation), 0);
    snoop(6'h05, 1'b0, '0);
    check("R9 invalid line", int'(violation), 0);
    check_load("R9 line unchanged", 6'h08, 1'b1, 8'hCD);

    // R12 snoop + commit + store in one cycle (line 0 is read)
    cpu(2'd0, 6'h09, 8'h21);
    snp_valid = 1'b1; snp_addr = 6'h08; snp_has_data = 1'b0; snp_data = '0;
    commit_done = 1'b1;
    cpu_op = 2'd2; cpu_addr = 6'h09; cpu_wdata = 8'h31;
    @(negedge clk);
    snp_valid = 1'b0; commit_done = 1'b0; cpu_op = 2'd3;
    check("R12 snoop beats commit", int'(violation), 1);
    ack();
    check_load("R12 store dropped", 6'h09, 1'b1, 8'h21);
    check_load("R12 read line invalidated", 6'h08, 1'b0, '0);
    commit_done = 1'b1;
    cpu_op = 2'd1; cpu_addr = 6'h09;
    @(negedge clk);
    commit_done = 1'b0; cpu_op = 2'd3;
    check("R12 commit beats load", int'(ld_hit), 0);
    check_load("R12 load after", 6'h09, 1'b1, 8'h21);
    commit();

    // R13 fill over a modified line
    cpu(2'd0, 6'h0A, 8'h50);
    cpu(2'd2, 6'h0A, 8'h51);
    cpu(2'd0, 6'h0E, 8'h60);
    check_load("R13 refused fill misses", 6'h0E, 1'b0, '0);
    check_load("R13 line kept", 6'h0A, 1'b1, 8'h51);
    commit();
    cpu(2'd0, 6'h0E, 8'h60);
    check_load("R13 fill after commit", 6'h0E, 1'b1, 8'h60);
    check("R13 no violation", int'(violation), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule